// File: doc/BRIEF.md
# Software Trigger Injection Unit

This block lets software fire triggers into a trigger routing fabric. Software writes a 32-bit command word over a simple write strobe. The word names a target group and a trigger number within it, a mode, and, for multiplexer groups, whether the hit lands on a multiplexer input or on a multiplexer output. The block drives the matching software trigger lines and ORs them onto the hardware trigger vectors that pass through it.

A multiplexer group has a set of outputs, and each output picks one input through a select value that arrives on a port. When software hits an input, every output whose select currently equals that input fires. When software hits an output, only that one output fires. One-to-one groups have direct lines only, so the side bit has no meaning for them.

In level mode the trigger stays asserted for as long as the activate bit is set. In edge mode the trigger is held for exactly two clock cycles, and the hardware then clears the activate bit. The command word can always be read back, and the activate bit reads live.

Top module: `swtrig_inject`

## Requirements
- R1: Out of reset the command word reads 0x0000_0000, and the outputs equal the hardware trigger inputs with no software trigger added.
- R2: A write made while activate is 0 loads the word. Bits 7:0 hold the trigger number, bits 12:8 the group, bit 29 the mode (1 = edge), bit 30 the side (1 = output side) and bit 31 activate. The readback presents these same positions. Bits 28:13 always read as 0.
- R3: In level mode the targeted trigger is asserted from the cycle after the activating write until activate is cleared. A write with bit 31 = 0 deasserts it at the next clock edge.
- R4: In edge mode the targeted trigger is high for exactly two cycles. Activate reads 0 from the cycle after the pulse.
- R5: For a multiplexer group (group 0 to 15) with bit 30 = 1, only output line group*OUTS+number of the multiplexer output vector is asserted.
- R6: For a multiplexer group with bit 30 = 0, every output of that group whose select port field equals the trigger number is asserted. The selection follows the select ports live.
- R7: For a one-to-one group (group 16 to 31), line (group-16)*LINES+number of the direct output vector is asserted, whatever the value of bit 30.
- R8: A trigger number or group that does not exist in the configuration asserts no output line.
- R9: While activate is 1, a write changes none of bits 30:0. A write with bit 31 = 1 has no effect at all.
- R10: Clearing activate in edge mode before the pulse ends removes the trigger at the next clock edge. Activate reads 0 from then on.
- R11: Each software trigger is ORed with the matching hardware trigger input. A hardware trigger is never masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word write data |
| rd_data | output | 32 | Command word readback |
| mux_sel_cfg | input | N_MUX_GRP*MUX_OUTS*IN_W | Input select of each multiplexer output, output 0 of group 0 at the bottom |
| hw_mux_trig | input | N_MUX_GRP*MUX_OUTS | Hardware multiplexer output triggers |
| hw_dir_trig | input | N_DIR_GRP*DIR_LINES | Hardware one-to-one triggers |
| mux_trig_out | output | N_MUX_GRP*MUX_OUTS | Multiplexer output triggers with software triggers merged |
| dir_trig_out | output | N_DIR_GRP*DIR_LINES | One-to-one triggers with software triggers merged |

## Verification
A write lands at the clock edge that captures it. The readback and the trigger outputs show its effect from that edge on. Select port and hardware trigger changes reach the outputs in the same cycle, with no register in between. The bench model updates on every rising edge and is compared 2 ns after each edge, once all those paths have settled. The directed checks sample one ns after a falling edge, so they count the two-cycle edge pulses and the shortened ones cycle by cycle.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;
  localparam int CMD_W    = 32;
  localparam int NUM_W    = 8;
  localparam int GRP_W    = 5;
  localparam int GRP_LSB  = 8;
  localparam int MODE_BIT = 29;
  localparam int SIDE_BIT = 30;
  localparam int ACT_BIT  = 31;
  localparam int DIR_BASE = 16;
  localparam int PAD_W    = MODE_BIT - (GRP_LSB + GRP_W);

  typedef struct packed {
    logic             act;
    logic             side;
    logic             edge_mode;
    logic [GRP_W-1:0] grp;
    logic [NUM_W-1:0] num;
  } swtrig_cmd_t;

  function automatic logic [CMD_W-1:0] cmd_to_word(swtrig_cmd_t c);
    return {c.act, c.side, c.edge_mode, {PAD_W{1'b0}}, c.grp, c.num};
  endfunction

  function automatic swtrig_cmd_t word_to_cmd(logic [CMD_W-1:0] w);
    swtrig_cmd_t c;
    c.act       = w[ACT_BIT];
    c.side      = w[SIDE_BIT];
    c.edge_mode = w[MODE_BIT];
    c.grp       = w[GRP_LSB +: GRP_W];
    c.num       = w[NUM_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/swtrig_cmd_reg.sv
module swtrig_cmd_reg
  import swtrig_pkg::*;
#(
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output swtrig_cmd_t      cmd
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

  swtrig_cmd_t      cmd_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             reg_en;
  logic             unused_pad;

  assign unused_pad = ^wr_data[MODE_BIT-1:GRP_LSB+GRP_W];
  assign reg_en     = wr_en | cmd.act;

  always_comb begin
    cmd_nxt = cmd;
    cnt_nxt = cnt_q;
    if (cmd.act) begin
      if (wr_en && !wr_data[ACT_BIT]) begin
        cmd_nxt.act = 1'b0;
      end else if (cmd.edge_mode) begin
        if (cnt_q == LAST) cmd_nxt.act = 1'b0;
        cnt_nxt = cnt_q + 1'b1;
      end
    end else if (wr_en) begin
      cmd_nxt = word_to_cmd(wr_data);
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      cmd   <= cmd_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/swtrig_mux_fanout.sv
module swtrig_mux_fanout
  import swtrig_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int N_OUT = 4,
  parameter int IN_W  = 3
) (
  input  swtrig_cmd_t                  cmd,
  input  logic [N_GRP*N_OUT*IN_W-1:0]  sel_cfg,
  output logic [N_GRP*N_OUT-1:0]       hit
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic grp_match;
    assign grp_match = cmd.act && (cmd.grp == GRP_W'(g));
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [IN_W-1:0] cfg_sel;
      logic            out_match, in_match;
      assign cfg_sel   = sel_cfg[(g*N_OUT+o)*IN_W +: IN_W];
      assign out_match = (cmd.num == NUM_W'(o));
      assign in_match  = (cmd.num == NUM_W'(cfg_sel));
      assign hit[g*N_OUT+o] = grp_match && (cmd.side ? out_match : in_match);
    end
  end
endmodule

// File: rtl/swtrig_dir_decode.sv
module swtrig_dir_decode
  import swtrig_pkg::*;
#(
  parameter int N_GRP   = 2,
  parameter int N_LINES = 4
) (
  input  swtrig_cmd_t              cmd,
  output logic [N_GRP*N_LINES-1:0] hit
);
  for (genvar d = 0; d < N_GRP; d++) begin : g_grp
    logic grp_match;
    assign grp_match = cmd.act && (cmd.grp == GRP_W'(DIR_BASE + d));
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
      assign hit[d*N_LINES+l] = grp_match && (cmd.num == NUM_W'(l));
    end
  end
endmodule

// File: rtl/swtrig_inject.sv
module swtrig_inject
  import swtrig_pkg::*;
#(
  parameter int N_MUX_GRP = 2,
  parameter int MUX_INS   = 8,
  parameter int MUX_OUTS  = 4,
  parameter int N_DIR_GRP = 2,
  parameter int DIR_LINES = 4,
  parameter int IN_W      = (MUX_INS > 1) ? $clog2(MUX_INS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [31:0]                       wr_data,
  output logic [31:0]                       rd_data,
  input  logic [N_MUX_GRP*MUX_OUTS*IN_W-1:0] mux_sel_cfg,
  input  logic [N_MUX_GRP*MUX_OUTS-1:0]     hw_mux_trig,
  input  logic [N_DIR_GRP*DIR_LINES-1:0]    hw_dir_trig,
  output logic [N_MUX_GRP*MUX_OUTS-1:0]     mux_trig_out,
  output logic [N_DIR_GRP*DIR_LINES-1:0]    dir_trig_out
);
  localparam int MUX_W = N_MUX_GRP * MUX_OUTS;
  localparam int DIR_W = N_DIR_GRP * DIR_LINES;

  swtrig_cmd_t      cmd;
  logic [MUX_W-1:0] mux_hit;
  logic [DIR_W-1:0] dir_hit;

  swtrig_cmd_reg #(.PULSE_CYCLES(2)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  swtrig_mux_fanout #(
    .N_GRP (N_MUX_GRP),
    .N_OUT (MUX_OUTS),
    .IN_W  (IN_W)
  ) u_mux (
    .cmd     (cmd),
    .sel_cfg (mux_sel_cfg),
    .hit     (mux_hit)
  );

  swtrig_dir_decode #(
    .N_GRP   (N_DIR_GRP),
    .N_LINES (DIR_LINES)
  ) u_dir (
    .cmd (cmd),
    .hit (dir_hit)
  );

  assign rd_data      = cmd_to_word(cmd);
  assign mux_trig_out = hw_mux_trig | mux_hit;
  assign dir_trig_out = hw_dir_trig | dir_hit;
endmodule

// File: rtl/swtrig_inject_chk.sv
module swtrig_inject_chk #(
  parameter int MUX_W = 8,
  parameter int DIR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      rd_data,
  input logic [MUX_W-1:0] hw_mux_trig,
  input logic [DIR_W-1:0] hw_dir_trig,
  input logic [MUX_W-1:0] mux_trig_out,
  input logic [DIR_W-1:0] dir_trig_out
);
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[28:13] == 16'h0);

  a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> (mux_trig_out == hw_mux_trig && dir_trig_out == hw_dir_trig));

  a_r11_hw_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((mux_trig_out & hw_mux_trig) == hw_mux_trig) && ((dir_trig_out & hw_dir_trig) == hw_dir_trig));

  a_r4_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && rd_data[29] && $past(rd_data[31]) && $past(rd_data[29])) |=> !rd_data[31]);

  a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_data[31]) |-> rd_data[30:0] == $past(rd_data[30:0]));

  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[31]) && !$past(rd_data[29]) && !$past(wr_en)) |-> rd_data[31]);
endmodule

bind swtrig_inject swtrig_inject_chk #(
  .MUX_W (N_MUX_GRP*MUX_OUTS),
  .DIR_W (N_DIR_GRP*DIR_LINES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_data      (rd_data),
  .hw_mux_trig  (hw_mux_trig),
  .hw_dir_trig  (hw_dir_trig),
  .mux_trig_out (mux_trig_out),
  .dir_trig_out (dir_trig_out)
);

// File: tb/tb_swtrig_inject.sv
`timescale 1ns/1ps
module tb_swtrig_inject;
  localparam int NMG = 2, MIN = 8, MOUT = 4, NDG = 2, DL = 4, IW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic [NMG*MOUT*IW-1:0] mux_sel_cfg;
  logic [NMG*MOUT-1:0] hw_mux_trig = '0;
  logic [NDG*DL-1:0] hw_dir_trig = '0;
  logic [NMG*MOUT-1:0] mux_trig_out;
  logic [NDG*DL-1:0] dir_trig_out;
  logic [IW-1:0]     cfg [NMG][MOUT];

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int g = 0; g < NMG; g++)
      for (int o = 0; o < MOUT; o++)
        mux_sel_cfg[(g*MOUT+o)*IW +: IW] = cfg[g][o];
  end

  swtrig_inject dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mux_sel_cfg(mux_sel_cfg), .hw_mux_trig(hw_mux_trig), .hw_dir_trig(hw_dir_trig),
    .mux_trig_out(mux_trig_out), .dir_trig_out(dir_trig_out)
  );

  // behavioural reference model
  bit m_act, m_side, m_edge;
  int m_grp, m_num, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_side <= 0; m_edge <= 0; m_grp <= 0; m_num <= 0; m_cnt <= 0;
    end else if (m_act) begin
      if (wr_en && !wr_data[31]) m_act <= 0;
      else if (m_edge) begin
        if (m_cnt >= 1) m_act <= 0;
        m_cnt <= m_cnt + 1;
      end
    end else if (wr_en) begin
      m_act  <= wr_data[31];
      m_side <= wr_data[30];
      m_edge <= wr_data[29];
      m_grp  <= int'(wr_data[12:8]);
      m_num  <= int'(wr_data[7:0]);
      m_cnt  <= 0;
    end
  end

  function automatic logic [31:0] exp_rd();
    return {m_act, m_side, m_edge, 16'h0, 5'(m_grp), 8'(m_num)};
  endfunction

  function automatic logic [NMG*MOUT-1:0] exp_mux();
    logic [NMG*MOUT-1:0] v = hw_mux_trig;
    for (int g = 0; g < NMG; g++)
      for (int o = 0; o < MOUT; o++)
        if (m_act && m_grp == g && (m_side ? (m_num == o) : (m_num == int'(cfg[g][o]))))
          v[g*MOUT+o] = 1'b1;
    return v;
  endfunction

  function automatic logic [NDG*DL-1:0] exp_dir();
    logic [NDG*DL-1:0] v = hw_dir_trig;
    for (int d = 0; d < NDG; d++)
      for (int l = 0; l < DL; l++)
        if (m_act && m_grp == 16 + d && m_num == l) v[d*DL+l] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check({cur_req, " model rd"},  rd_data, exp_rd());
      check({cur_req, " model mux"}, 32'(mux_trig_out), 32'(exp_mux()));
      check({cur_req, " model dir"}, 32'(dir_trig_out), 32'(exp_dir()));
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    cfg[0][0] = 3; cfg[0][1] = 5; cfg[0][2] = 3; cfg[0][3] = 0;
    for (int o = 0; o < MOUT; o++) cfg[1][o] = 1;
    idle(3);
    check("R1 reset rd", rd_data, 32'h0);
    check("R1 reset mux", 32'(mux_trig_out), 32'h0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release dir", 32'(dir_trig_out), 32'h0);

    cur_req = "R2";
    wr(32'h3FFF_E105);
    check("R2 readback pad zero", rd_data, 32'h2000_0105);
    check("R2 no activation", 32'(mux_trig_out), 32'h0);

    cur_req = "R5";
    wr(32'hC000_0002);
    check("R5 output side line", 32'(mux_trig_out), 32'h04);
    idle(3);
    check("R3 level persists", 32'(mux_trig_out), 32'h04);
    cur_req = "R3";
    wr(32'h0000_0000);
    check("R3 clear deasserts", 32'(mux_trig_out), 32'h0);
    check("R3 fields kept", rd_data, 32'h4000_0002);

    cur_req = "R6";
    wr(32'h8000_0003);
    check("R6 input fan-out", 32'(mux_trig_out), 32'h05);
    cfg[0][1] = 3; #1;
    check("R6 live select", 32'(mux_trig_out), 32'h07);
    cfg[0][1] = 5; #1;
    wr(32'h0);
    wr(32'h8000_0101);
    check("R6 group1 all outputs", 32'(mux_trig_out), 32'hF0);
    wr(32'h0);

    cur_req = "R4";
    wr(32'hE000_0001);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      if (mux_trig_out[1]) cnt++;
      @(negedge clk); #1;
    end
    check("R4 pulse length", 32'(cnt), 32'd2);
    check("R4 activate self-cleared", 32'(rd_data[31]), 32'd0);

    cur_req = "R7";
    wr(32'hC000_1002);
    check("R7 direct line side 1", 32'(dir_trig_out), 32'h04);
    check("R7 no mux line", 32'(mux_trig_out), 32'h0);
    wr(32'h0);
    wr(32'h8000_1102);
    check("R7 direct line side 0", 32'(dir_trig_out), 32'h40);
    wr(32'h0);

    cur_req = "R8";
    wr(32'hC000_0009);
    check("R8 number out of range", 32'({mux_trig_out, dir_trig_out}), 32'h0);
    wr(32'h0);
    wr(32'hC000_0200);
    check("R8 missing mux group", 32'({mux_trig_out, dir_trig_out}), 32'h0);
    wr(32'h0);
    wr(32'hC000_1200);
    check("R8 missing direct group", 32'({mux_trig_out, dir_trig_out}), 32'h0);
    wr(32'h0);
    wr(32'hC000_1004);
    check("R8 direct line out of range", 32'({mux_trig_out, dir_trig_out}), 32'h0);
    wr(32'h0);

    cur_req = "R9";
    wr(32'hC000_0001);
    wr(32'hC000_0003);
    check("R9 rd unchanged", rd_data, 32'hC000_0001);
    check("R9 output unchanged", 32'(mux_trig_out), 32'h02);
    wr(32'h0000_0003);
    check("R9 clear keeps fields", rd_data, 32'h4000_0001);

    cur_req = "R10";
    wr(32'hE000_0002);
    wr_en = 1'b1; wr_data = 32'h0;
    cnt = 0;
    if (mux_trig_out[2]) cnt++;
    @(negedge clk); wr_en = 1'b0; #1;
    for (int i = 0; i < 3; i++) begin
      if (mux_trig_out[2]) cnt++;
      @(negedge clk); #1;
    end
    check("R10 pulse cut short", 32'(cnt), 32'd1);
    check("R10 activate cleared", 32'(rd_data[31]), 32'd0);

    cur_req = "R11";
    hw_mux_trig = 8'hA5; hw_dir_trig = 8'h3C; #1;
    check("R11 hw mux passthrough", 32'(mux_trig_out), 32'hA5);
    check("R11 hw dir passthrough", 32'(dir_trig_out), 32'h3C);
    wr(32'hC000_0001);
    check("R11 merged mux", 32'(mux_trig_out), 32'hA7);
    wr(32'hC000_0001);
    wr(32'h0);
    wr(32'hC000_1000);
    check("R11 merged dir", 32'(dir_trig_out), 32'h3D);
    wr(32'h0);
    hw_mux_trig = '0; hw_dir_trig = '0;
    idle(3);
    finish_run();
  end
endmodule